// File: doc/BRIEF.md
# Descriptor-Driven Waveform State Machine Engine

This block is a finite state machine whose behaviour is not fixed in logic. It is defined by a descriptor table that software fills through a simple register-write port while the machine is stopped. Each state entry holds three things: a vector of outputs that stay driven while the machine sits in that state, a set of state actions, and two candidate transitions. A transition names four condition inputs. Those four bits index a 16-bit truth table. When the indexed bit is 1, the transition is taken: the machine moves to the transition's target state and, in that cycle only, drives the transition's pulse vector.

An internal data counter is controlled by the state actions. A state can load the counter, which clears the count and sets a limit. A state can also increment the counter. The counter's limit flag is wired back as the highest-numbered condition input, so a descriptor can loop until a programmed number of cycles has passed. A state can also be marked as interrupting: the interrupt line is then high, and a state-number output always shows where the machine is.

Control inputs start the machine from a chosen state, stop it, pause and resume it, and switch it to another state without stopping it.

Top module: `wfe_engine`

## Requirements
- R1: After reset the machine is stopped, with hold_o, pulse_o, irq_o and err_o all zero.
- R2: A descriptor write while stopped stores wr_data_i at wr_addr_i = {state, field[2:0]}. The fields are:
  - Field 0: hold vector in data[HOLD_W-1:0].
  - Field 1: actions. Bit 0 is counter load, bit 1 is counter increment, bit 2 is interrupt, and the limit sits in data[16+:CNT_W].
  - Fields 2 and 4: the routing word of transitions 0 and 1. Select k is in data[5k+4:5k] and the target state is in data[31:24].
  - Fields 3 and 5: the truth table of transitions 0 and 1 in data[15:0], with the pulse vector in data[16+:PULSE_W].
  
  A start pulse while stopped enters start_state_i at the next edge, and hold_o then shows that state's hold vector.
- R3: A transition forms the index {c3,c2,c1,c0}, where ck is the condition bit named by select k, and is taken when its table bit at that index is 1. The machine reaches the target state at the next edge.
- R4: Transition 0 wins when both transitions match. When neither matches, the state does not change.
- R5: pulse_o carries the taken transition's pulse vector during the cycle before the edge that takes it. It is zero in every other cycle.
- R6: The load action clears the count and sets the limit. The increment action adds one per running cycle up to the limit. Condition index 31 (the one above the 31 external inputs) is 1 while count equals limit.
- R7: A pause freezes the state, the counter and hold_o, and it suppresses pulses, including in the cycle pause_i is raised. Resume continues from the frozen point.
- R8: A switch moves the machine to switch_state_i at the next edge whether it is running or paused. The machine keeps running, or stays paused.
- R9: irq_o is high while the machine is active in a state whose interrupt action is set. irq_state_o always shows the current state number.
- R10: A descriptor write while running or paused changes nothing and sets err_o, which stays set until reset.
- R11: A stop returns the machine to the stopped mode, with hold_o and irq_o zero. A start pulse while active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_addr_i | input | STATE_W+3 | Descriptor address {state, field} |
| wr_data_i | input | 32 | Descriptor write data |
| start_i | input | 1 | Start from start_state_i |
| start_state_i | input | STATE_W | Initial state for start |
| stop_i | input | 1 | Return to stopped mode |
| pause_i | input | 1 | Freeze execution |
| resume_i | input | 1 | Continue after pause |
| switch_i | input | 1 | Jump to switch_state_i without stopping |
| switch_state_i | input | STATE_W | Target state for switch |
| cond_i | input | EXT_W | External condition inputs |
| hold_o | output | HOLD_W | State-held outputs |
| pulse_o | output | PULSE_W | Transition pulse outputs |
| irq_o | output | 1 | Interrupt request |
| irq_state_o | output | STATE_W | Current state number |
| err_o | output | 1 | Sticky write-while-active error |

## Verification
The transition logic is exercised with several condition patterns:
- All conditions clear, which leaves the machine in place.
- A near miss that differs from the matching index in one selected bit, which catches wrong select routing or bit order.
- A pattern that matches only transition 1, which shows both evaluators work.
- A pattern that matches both transitions, which shows transition 0 wins.

The counter loop is paused in the middle of counting. Reaching the limit exactly two cycles after resume separates a correct freeze from a counter that keeps running or a pause that loses cycles. Switching while paused, then applying a condition pattern that matches, shows that a switch does not release the pause.

// File: rtl/wfe_pkg.sv
package wfe_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_RUN   = 2'd1,
      MODE_PAUSE = 2'd2
   } mode_e;

   localparam int WR_DW   = 32;
   localparam int N_TR    = 2;
   localparam int FLD_W   = 3;

   localparam int FLD_HOLD  = 0;
   localparam int FLD_ACT   = 1;
   localparam int FLD_ROUTE = 2;   // transition t routing at FLD_ROUTE + 2*t
   localparam int FLD_TAB   = 3;   // transition t table at FLD_TAB + 2*t

   localparam int ACT_LOAD  = 0;
   localparam int ACT_INC   = 1;
   localparam int ACT_IRQ   = 2;
   localparam int LIM_LSB   = 16;
   localparam int NXT_LSB   = 24;
   localparam int PLS_LSB   = 16;

endpackage

// File: rtl/wfe_cond_match.sv
module wfe_cond_match #(
   parameter int N_COND = 32,
   parameter int SEL_W  = 5
) (
   input  logic [N_COND-1:0]  cond,
   input  logic [4*SEL_W-1:0] sel,
   input  logic [15:0]        tab,
   output logic               hit
);

   logic [3:0] idx;

   for (genvar k = 0; k < 4; k++) begin : g_pick
      logic [SEL_W-1:0] s;
      assign s = sel[k*SEL_W +: SEL_W];
      if (N_COND == (1 << SEL_W)) begin : g_full
         assign idx[k] = cond[s];
      end else begin : g_guard
         assign idx[k] = (32'(s) < 32'(N_COND)) ? cond[s] : 1'b0;
      end
   end

   assign hit = tab[idx];

endmodule

// File: rtl/wfe_data_counter.sv
module wfe_data_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             load,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit_in,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '1;
      end else if (clr) begin
         cnt_q <= '0;
         lim_q <= '1;
      end else if (en) begin
         if (load) begin
            cnt_q <= '0;
            lim_q <= limit_in;
         end else if (inc && (cnt_q != lim_q)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign hit = (cnt_q == lim_q);

endmodule

// File: rtl/wfe_desc_mem.sv
module wfe_desc_mem
   import wfe_pkg::*;
#(
   parameter int STATE_W = 8,
   parameter int HOLD_W  = 31,
   parameter int PULSE_W = 8,
   parameter int CNT_W   = 16,
   parameter int SEL_W   = 5
) (
   input  logic                          clk,
   input  logic                          wr_en,
   input  logic [STATE_W-1:0]            wr_state,
   input  logic [FLD_W-1:0]              wr_fld,
   input  logic [WR_DW-1:0]              wr_data,
   input  logic [STATE_W-1:0]            rd_state,
   output logic [HOLD_W-1:0]             hold,
   output logic                          act_load,
   output logic                          act_inc,
   output logic                          act_irq,
   output logic [CNT_W-1:0]              limit,
   output logic [N_TR-1:0][4*SEL_W-1:0]  t_sel,
   output logic [N_TR-1:0][STATE_W-1:0]  t_next,
   output logic [N_TR-1:0][15:0]         t_tab,
   output logic [N_TR-1:0][PULSE_W-1:0]  t_pls
);

   localparam int NSTATE = 1 << STATE_W;
   localparam int ACT_W  = 3 + CNT_W;

   logic [HOLD_W-1:0] hold_mem [NSTATE];
   logic [ACT_W-1:0]  act_mem  [NSTATE];
   logic [ACT_W-1:0]  act_rd;
   logic              unused_wr;

   assign unused_wr = ^wr_data;

   always_ff @(posedge clk) begin
      if (wr_en && wr_fld == FLD_W'(FLD_HOLD))
         hold_mem[wr_state] <= wr_data[HOLD_W-1:0];
      if (wr_en && wr_fld == FLD_W'(FLD_ACT))
         act_mem[wr_state] <= {wr_data[LIM_LSB +: CNT_W], wr_data[2:0]};
   end

   assign hold     = hold_mem[rd_state];
   assign act_rd   = act_mem[rd_state];
   assign act_load = act_rd[ACT_LOAD];
   assign act_inc  = act_rd[ACT_INC];
   assign act_irq  = act_rd[ACT_IRQ];
   assign limit    = act_rd[ACT_W-1:3];

   for (genvar t = 0; t < N_TR; t++) begin : g_tr
      localparam logic [FLD_W-1:0] F_ROUTE = FLD_W'(FLD_ROUTE + 2*t);
      localparam logic [FLD_W-1:0] F_TAB   = FLD_W'(FLD_TAB + 2*t);

      logic [4*SEL_W-1:0] sel_mem [NSTATE];
      logic [STATE_W-1:0] nxt_mem [NSTATE];
      logic [15:0]        tab_mem [NSTATE];
      logic [PULSE_W-1:0] pls_mem [NSTATE];

      always_ff @(posedge clk) begin
         if (wr_en && wr_fld == F_ROUTE) begin
            sel_mem[wr_state] <= wr_data[4*SEL_W-1:0];
            nxt_mem[wr_state] <= wr_data[NXT_LSB +: STATE_W];
         end
         if (wr_en && wr_fld == F_TAB) begin
            tab_mem[wr_state] <= wr_data[15:0];
            pls_mem[wr_state] <= wr_data[PLS_LSB +: PULSE_W];
         end
      end

      assign t_sel[t]  = sel_mem[rd_state];
      assign t_next[t] = nxt_mem[rd_state];
      assign t_tab[t]  = tab_mem[rd_state];
      assign t_pls[t]  = pls_mem[rd_state];
   end

endmodule

// File: rtl/wfe_engine.sv
module wfe_engine
   import wfe_pkg::*;
#(
   parameter int STATE_W = 8,
   parameter int EXT_W   = 31,
   parameter int HOLD_W  = 31,
   parameter int PULSE_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [STATE_W+2:0]   wr_addr_i,
   input  logic [31:0]          wr_data_i,
   input  logic                 start_i,
   input  logic [STATE_W-1:0]   start_state_i,
   input  logic                 stop_i,
   input  logic                 pause_i,
   input  logic                 resume_i,
   input  logic                 switch_i,
   input  logic [STATE_W-1:0]   switch_state_i,
   input  logic [EXT_W-1:0]     cond_i,
   output logic [HOLD_W-1:0]    hold_o,
   output logic [PULSE_W-1:0]   pulse_o,
   output logic                 irq_o,
   output logic [STATE_W-1:0]   irq_state_o,
   output logic                 err_o
);

   localparam int N_COND = EXT_W + 1;
   localparam int SEL_W  = (N_COND > 1) ? $clog2(N_COND) : 1;

   if (STATE_W < 1 || STATE_W > 8) begin : g_chk_state
      $error("STATE_W must be 1..8");
   end
   if (N_COND > 32 || 4*SEL_W > NXT_LSB) begin : g_chk_cond
      $error("EXT_W too large for routing word");
   end
   if (HOLD_W < 1 || HOLD_W > 32) begin : g_chk_hold
      $error("HOLD_W must be 1..32");
   end
   if (PULSE_W < 1 || PULSE_W > 16 || CNT_W < 1 || CNT_W > 16) begin : g_chk_pc
      $error("PULSE_W and CNT_W must be 1..16");
   end

   mode_e                        mode;
   logic [STATE_W-1:0]           cur;
   logic                         err_q;

   logic [HOLD_W-1:0]            hold_rd;
   logic                         act_load, act_inc, act_irq;
   logic [CNT_W-1:0]             limit;
   logic [N_TR-1:0][4*SEL_W-1:0] t_sel;
   logic [N_TR-1:0][STATE_W-1:0] t_next;
   logic [N_TR-1:0][15:0]        t_tab;
   logic [N_TR-1:0][PULSE_W-1:0] t_pls;
   logic [N_TR-1:0]              t_hit;

   logic                         cnt_hit;
   logic [N_COND-1:0]            cond_all;
   logic                         take;
   logic [STATE_W-1:0]           nxt;
   logic [PULSE_W-1:0]           pls;
   logic                         adv;
   logic                         cnt_en;
   logic                         cnt_clr;

   wfe_desc_mem #(
      .STATE_W (STATE_W), .HOLD_W (HOLD_W), .PULSE_W (PULSE_W),
      .CNT_W   (CNT_W),   .SEL_W  (SEL_W)
   ) u_mem (
      .clk      (clk),
      .wr_en    (wr_en_i && (mode == MODE_IDLE)),
      .wr_state (wr_addr_i[STATE_W+2:3]),
      .wr_fld   (wr_addr_i[2:0]),
      .wr_data  (wr_data_i),
      .rd_state (cur),
      .hold     (hold_rd),
      .act_load (act_load),
      .act_inc  (act_inc),
      .act_irq  (act_irq),
      .limit    (limit),
      .t_sel    (t_sel),
      .t_next   (t_next),
      .t_tab    (t_tab),
      .t_pls    (t_pls)
   );

   assign cond_all = {cnt_hit, cond_i};

   for (genvar t = 0; t < N_TR; t++) begin : g_eval
      wfe_cond_match #(.N_COND (N_COND), .SEL_W (SEL_W)) u_match (
         .cond (cond_all),
         .sel  (t_sel[t]),
         .tab  (t_tab[t]),
         .hit  (t_hit[t])
      );
   end

   assign take = |t_hit;
   assign nxt  = t_hit[0] ? t_next[0] : t_next[1];
   assign pls  = t_hit[0] ? t_pls[0]  : t_pls[1];

   assign adv     = (mode == MODE_RUN) && !stop_i && !pause_i && !switch_i;
   assign cnt_en  = (mode == MODE_RUN) && !stop_i && !pause_i;
   assign cnt_clr = (mode == MODE_IDLE) && start_i && !stop_i;

   wfe_data_counter #(.CNT_W (CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .en       (cnt_en),
      .load     (act_load),
      .inc      (act_inc),
      .limit_in (limit),
      .hit      (cnt_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= MODE_IDLE;
         cur   <= '0;
         err_q <= 1'b0;
      end else begin
         if (wr_en_i && (mode != MODE_IDLE))
            err_q <= 1'b1;
         if (stop_i) begin
            mode <= MODE_IDLE;
         end else begin
            case (mode)
               MODE_IDLE: begin
                  if (start_i) begin
                     mode <= MODE_RUN;
                     cur  <= start_state_i;
                  end
               end
               MODE_RUN: begin
                  if (switch_i)
                     cur <= switch_state_i;
                  else if (!pause_i && take)
                     cur <= nxt;
                  if (pause_i)
                     mode <= MODE_PAUSE;
               end
               MODE_PAUSE: begin
                  if (switch_i)
                     cur <= switch_state_i;
                  if (resume_i)
                     mode <= MODE_RUN;
               end
               default: mode <= MODE_IDLE;
            endcase
         end
      end
   end

   assign hold_o      = (mode != MODE_IDLE) ? hold_rd : '0;
   assign pulse_o     = (adv && take) ? pls : '0;
   assign irq_o       = (mode != MODE_IDLE) && act_irq;
   assign irq_state_o = cur;
   assign err_o       = err_q;

endmodule

// File: rtl/wfe_engine_chk.sv
module wfe_engine_chk
   import wfe_pkg::*;
#(
   parameter int STATE_W = 8,
   parameter int HOLD_W  = 31,
   parameter int PULSE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input mode_e              mode,
   input logic               start_i,
   input logic [STATE_W-1:0] start_state_i,
   input logic               stop_i,
   input logic               pause_i,
   input logic               switch_i,
   input logic [STATE_W-1:0] switch_state_i,
   input logic               wr_en_i,
   input logic [HOLD_W-1:0]  hold_o,
   input logic [PULSE_W-1:0] pulse_o,
   input logic [STATE_W-1:0] irq_state_o,
   input logic               err_o
);

   assert_start_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_IDLE && start_i && !stop_i)
      |=> (mode == MODE_RUN && irq_state_o == $past(start_state_i)));

   assert_pulse_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o != '0) |-> (mode == MODE_RUN && !pause_i));

   assert_pause_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PAUSE && !switch_i && !stop_i)
      |=> ($stable(irq_state_o) && $stable(hold_o)));

   assert_switch_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_IDLE && switch_i && !stop_i)
      |=> (irq_state_o == $past(switch_state_i) && mode != MODE_IDLE));

   assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && mode != MODE_IDLE) |=> err_o);

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (mode == MODE_IDLE && hold_o == '0));

endmodule

bind wfe_engine wfe_engine_chk #(
   .STATE_W (STATE_W), .HOLD_W (HOLD_W), .PULSE_W (PULSE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode           (mode),
   .start_i        (start_i),
   .start_state_i  (start_state_i),
   .stop_i         (stop_i),
   .pause_i        (pause_i),
   .switch_i       (switch_i),
   .switch_state_i (switch_state_i),
   .wr_en_i        (wr_en_i),
   .hold_o         (hold_o),
   .pulse_o        (pulse_o),
   .irq_state_o    (irq_state_o),
   .err_o          (err_o)
);

// File: tb/wfe_engine_test.sv
`timescale 1ns/1ps
module wfe_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [10:0] wr_addr_i = '0;
   logic [31:0] wr_data_i = '0;
   logic        start_i = 1'b0;
   logic [7:0]  start_state_i = '0;
   logic        stop_i = 1'b0;
   logic        pause_i = 1'b0;
   logic        resume_i = 1'b0;
   logic        switch_i = 1'b0;
   logic [7:0]  switch_state_i = '0;
   logic [30:0] cond_i = '0;
   logic [30:0] hold_o;
   logic [7:0]  pulse_o;
   logic        irq_o;
   logic [7:0]  irq_state_o;
   logic        err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wfe_engine uut (
      .clk (clk), .rst_n (rst_n),
      .wr_en_i (wr_en_i), .wr_addr_i (wr_addr_i), .wr_data_i (wr_data_i),
      .start_i (start_i), .start_state_i (start_state_i),
      .stop_i (stop_i), .pause_i (pause_i), .resume_i (resume_i),
      .switch_i (switch_i), .switch_state_i (switch_state_i),
      .cond_i (cond_i),
      .hold_o (hold_o), .pulse_o (pulse_o), .irq_o (irq_o),
      .irq_state_o (irq_state_o), .err_o (err_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] st, input logic [2:0] f, input logic [31:0] d);
      wr_en_i = 1'b1; wr_addr_i = {st, f}; wr_data_i = d;
      step();
      wr_en_i = 1'b0;
   endtask

   task automatic prog(input logic [7:0] st, input logic [31:0] hold, input logic [31:0] act,
                       input logic [31:0] r0, input logic [31:0] t0,
                       input logic [31:0] r1, input logic [31:0] t1);
      wr(st, 3'd0, hold); wr(st, 3'd1, act);
      wr(st, 3'd2, r0);   wr(st, 3'd3, t0);
      wr(st, 3'd4, r1);   wr(st, 3'd5, t1);
   endtask

   function automatic logic [31:0] route(input int s0, input int s1, input int s2, input int s3,
                                         input int nx);
      return (32'(nx) << 24) | (32'(s3) << 15) | (32'(s2) << 10) | (32'(s1) << 5) | 32'(s0);
   endfunction

   task automatic do_switch(input logic [7:0] st);
      switch_i = 1'b1; switch_state_i = st;
      step();
      switch_i = 1'b0;
      #2;
   endtask

   task automatic t_reset();
      #2;
      chk("R1 hold", 32'(hold_o), 0);
      chk("R1 pulse", 32'(pulse_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 err", 32'(err_o), 0);
   endtask

   task automatic t_program();
      prog(8'd1, 32'h11, 0, route(0,1,2,3,2), 32'h0001_0020, route(4,5,6,7,3), 32'h0002_8000);
      prog(8'd2, 32'h22, 32'h4, 0, 0, 0, 0);
      prog(8'd3, 32'h33, 0, route(0,0,0,0,1), 32'h0008_0001, 0, 0);
      prog(8'd4, 32'h44, 32'h0003_0001, route(0,0,0,0,5), 32'h0010_FFFF, 0, 0);
      prog(8'd5, 32'h55, 32'h2, route(31,31,31,31,6), 32'h0020_8000, 0, 0);
      prog(8'd6, 32'h66, 0, 0, 0, 0, 0);
      #2;
      chk("R10 no error while stopped", 32'(err_o), 0);
   endtask

   task automatic t_start_trans();
      start_i = 1'b1; start_state_i = 8'd1;
      step();
      start_i = 1'b0;
      #2;
      chk("R2 start state", 32'(irq_state_o), 1);
      chk("R2 hold of state", 32'(hold_o), 32'h11);
      cond_i = '0; #2;
      chk("R4 no match pulse", 32'(pulse_o), 0);
      step(); #2;
      chk("R4 no match stays", 32'(irq_state_o), 1);
      cond_i = 31'h7; #2;
      chk("R3 near miss pulse", 32'(pulse_o), 0);
      step(); #2;
      chk("R3 near miss stays", 32'(irq_state_o), 1);
      cond_i = 31'h5; #2;
      chk("R5 pulse on match", 32'(pulse_o), 32'h01);
      step(); #2;
      chk("R3 target reached", 32'(irq_state_o), 2);
      chk("R5 pulse gone", 32'(pulse_o), 0);
      chk("R9 irq set", 32'(irq_o), 1);
      chk("R9 hold of irq state", 32'(hold_o), 32'h22);
   endtask

   task automatic t_priority();
      cond_i = '0;
      do_switch(8'd1);
      chk("R8 switch target", 32'(irq_state_o), 1);
      chk("R8 still running", 32'(hold_o), 32'h11);
      chk("R9 irq clear", 32'(irq_o), 0);
      cond_i = 31'hF5; #2;
      chk("R4 both match pulse", 32'(pulse_o), 32'h01);
      step(); #2;
      chk("R4 transition 0 wins", 32'(irq_state_o), 2);
      cond_i = 31'hF0;
      do_switch(8'd1);
      chk("R4 only t1 pulse", 32'(pulse_o), 32'h02);
      step(); #2;
      chk("R4 only t1 target", 32'(irq_state_o), 3);
      chk("R5 state3 pulse", 32'(pulse_o), 32'h08);
      step(); #2;
      chk("R3 back to 1", 32'(irq_state_o), 1);
   endtask

   task automatic t_pause();
      cond_i = 31'hF5; pause_i = 1'b1; #2;
      chk("R7 pulse blocked on pause", 32'(pulse_o), 0);
      step();
      pause_i = 1'b0;
      step(); step(); #2;
      chk("R7 state frozen", 32'(irq_state_o), 1);
      chk("R7 hold frozen", 32'(hold_o), 32'h11);
      chk("R7 no pulse paused", 32'(pulse_o), 0);
      cond_i = 31'hF0;
      do_switch(8'd3);
      chk("R8 switch while paused", 32'(irq_state_o), 3);
      chk("R8 paused no pulse", 32'(pulse_o), 0);
      step(); #2;
      chk("R8 stays paused", 32'(irq_state_o), 3);
      resume_i = 1'b1;
      step();
      resume_i = 1'b0; #2;
      chk("R7 resume no jump", 32'(irq_state_o), 3);
      chk("R7 resumed pulse", 32'(pulse_o), 32'h08);
      cond_i = '0;
      step(); #2;
      chk("R7 resumed transition", 32'(irq_state_o), 1);
   endtask

   task automatic t_counter();
      do_switch(8'd4);
      chk("R6 load state pulse", 32'(pulse_o), 32'h10);
      step(); #2;
      chk("R6 in count state", 32'(irq_state_o), 5);
      chk("R6 no hit at 0", 32'(pulse_o), 0);
      step();
      pause_i = 1'b1; step(); pause_i = 1'b0;
      step();
      resume_i = 1'b1; step(); resume_i = 1'b0; #2;
      chk("R6 no hit at 1", 32'(pulse_o), 0);
      step(); #2;
      chk("R6 no hit at 2", 32'(pulse_o), 0);
      chk("R6 still counting", 32'(irq_state_o), 5);
      step(); #2;
      chk("R6 hit at limit", 32'(pulse_o), 32'h20);
      step(); #2;
      chk("R6 exit on hit", 32'(irq_state_o), 6);
   endtask

   task automatic t_switch_write_stop();
      do_switch(8'd2);
      chk("R8 switch from running", 32'(irq_state_o), 2);
      chk("R9 irq state", 32'(irq_o), 1);
      wr(8'd2, 3'd0, 32'hABC); #2;
      chk("R10 err set", 32'(err_o), 1);
      chk("R10 hold unchanged", 32'(hold_o), 32'h22);
      start_i = 1'b1; start_state_i = 8'd3;
      step();
      start_i = 1'b0; #2;
      chk("R11 start ignored active", 32'(irq_state_o), 2);
      stop_i = 1'b1;
      step();
      stop_i = 1'b0; #2;
      chk("R11 hold zero stopped", 32'(hold_o), 0);
      chk("R11 irq zero stopped", 32'(irq_o), 0);
      chk("R10 err sticky", 32'(err_o), 1);
      start_i = 1'b1; start_state_i = 8'd2;
      step();
      start_i = 1'b0; #2;
      chk("R10 write was ignored", 32'(hold_o), 32'h22);
   endtask

   initial begin
      step(); step();
      rst_n = 1'b1;
      t_reset();
      step();
      t_program();
      t_start_trans();
      t_priority();
      t_pause();
      t_counter();
      t_switch_write_stop();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule